// File: doc/BRIEF.md
# Self-Clearing Pulse Control Register Block

This block is a small memory-mapped register file driven by a one-cycle CPU request port. The port carries a valid flag, a write flag, an address and write data. Every request gets a registered response one clock later. Each field's next value comes from a fixed ranking of conditions:

- software read side effects, highest;
- software write actions;
- a self-clear rule;
- hardware updates, lowest.

All field values are presented to the surrounding logic straight from their flops.

The main register, at address 0, holds a row of single-pulse bits. Writing a 1 to one of these bits drives the matching hardware output high for exactly one clock. After that the bit returns to 0 with no further action. The self-clear rule is always active, but a software write outranks it.

Two other registers show the rest of the ranking:
- a plain configuration register at address 1;
- a capture register at address 2. Hardware loads it through an enable. A software read clears it, and a software write ORs bits into it.

Top module: `spr_regblock`

## Requirements
- R1: While `rst` is high on a rising edge, `pulse_out` becomes 0, `cfg_out` becomes `CFG_RST`, the capture register becomes 0, `resp_ready` becomes 0 and `resp_rdata` becomes 0.
- R2: A write to address 0 with data bit i set drives `pulse_out[i]` high for exactly the one cycle after the request. It is low again in the following cycle unless another such write arrives.
- R3: A write to address 0 with data bit i clear leaves `pulse_out[i]` low in every following cycle.
- R4: Writes to address 0 on consecutive cycles make `pulse_out` follow each request's data bits in successive cycles, one cycle per write. It returns to 0 one cycle after the last write.
- R5: A read of address 0 issued after a pulse has ended returns 0 in bits [PW-1:0].
- R6: Address 1 holds the last value written to it, drives it on `cfg_out`, and returns it on a read. It changes only on a write to address 1.
- R7: When `cap_we` is high and no software access to address 2 occurs in that cycle, the capture register loads `cap_data` at the clock edge.
- R8: A read of address 2 returns the capture value held at request time and clears the register. The read-clear wins over a simultaneous `cap_we`.
- R9: A write to address 2 ORs the write data into the capture register. This write-to-set wins over a simultaneous `cap_we`.
- R10: `resp_ready` is high in exactly the cycle after each request. `resp_rdata` in that cycle is the read value for reads and 0 for writes. Addresses 3 and above read as 0, and writes to them change no register.
- R11: A reset that arrives during operation returns every output to its R1 value at the next edge, including a pulse bit set in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Register address |
| req_wdata | input | DW | Write data |
| resp_ready | output | 1 | Response valid, one cycle after a request |
| resp_rdata | output | DW | Read data for the request answered |
| pulse_out | output | PW | Single-pulse field outputs |
| cfg_out | output | DW | Configuration register value |
| cap_we | input | 1 | Hardware load enable for the capture register |
| cap_data | input | DW | Hardware value for the capture register |

## Verification
The bound checker watches several rules on every clock:
- the pulse outputs equal the previous cycle's address-0 write data, or 0 when there was no such write;
- the response strobe trails each request by one cycle;
- the configuration value holds when address 1 is not written;
- the capture register is clear after a read and holds the written bits after a write.

The bench's directed scenarios show the rest:
- what a read actually returns after a pulse has ended;
- a hardware load lost to a simultaneous read-clear;
- the OR result when a write and a hardware load meet;
- the silence of unmapped addresses;
- a reset arriving mid-pulse.

// File: rtl/spr_pkg.sv
package spr_pkg;
  typedef enum logic [1:0] {
    FK_PULSE   = 2'd0,
    FK_RW      = 2'd1,
    FK_CAPTURE = 2'd2
  } field_kind_e;

  localparam int unsigned REG_PULSE = 0;
  localparam int unsigned REG_CFG   = 1;
  localparam int unsigned REG_CAP   = 2;
  localparam int unsigned NUM_REGS  = 3;
endpackage

// File: rtl/spr_decode.sv
module spr_decode #(
  parameter int unsigned AW   = 4,
  parameter int unsigned NREG = 3
) (
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  output logic [NREG-1:0] wr_sel,
  output logic [NREG-1:0] rd_sel
);
  for (genvar g = 0; g < NREG; g++) begin : g_sel
    localparam logic [AW-1:0] MY_ADDR = AW'(g);
    logic hit;
    assign hit       = req_valid && (req_addr == MY_ADDR);
    assign wr_sel[g] = hit && req_write;
    assign rd_sel[g] = hit && !req_write;
  end
endmodule

// File: rtl/spr_field.sv
module spr_field
  import spr_pkg::*;
#(
  parameter field_kind_e  KIND = FK_RW,
  parameter int unsigned  W    = 1,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sw_rd,
  input  logic         sw_wr,
  input  logic [W-1:0] sw_wdata,
  input  logic         hw_we,
  input  logic [W-1:0] hw_wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;
  logic         load;

  // Ranked next-state choice: read effect, write action, self-clear, hw update
  always_comb begin
    nxt  = q;
    load = 1'b0;
    if (KIND == FK_CAPTURE && sw_rd) begin
      nxt  = '0;
      load = 1'b1;
    end else if (sw_wr) begin
      nxt  = (KIND == FK_CAPTURE) ? (q | sw_wdata) : sw_wdata;
      load = 1'b1;
    end else if (KIND == FK_PULSE) begin
      nxt  = '0;
      load = 1'b1;
    end else if (KIND == FK_CAPTURE && hw_we) begin
      nxt  = hw_wdata;
      load = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       q <= RST;
    else if (load) q <= nxt;
  end
endmodule

// File: rtl/spr_regblock.sv
module spr_regblock
  import spr_pkg::*;
#(
  parameter int unsigned   AW      = 4,
  parameter int unsigned   DW      = 8,
  parameter int unsigned   PW      = 4,
  parameter logic [DW-1:0] CFG_RST = 8'hA5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          resp_ready,
  output logic [DW-1:0] resp_rdata,
  output logic [PW-1:0] pulse_out,
  output logic [DW-1:0] cfg_out,
  input  logic          cap_we,
  input  logic [DW-1:0] cap_data
);
  localparam int unsigned NREG = NUM_REGS;

  logic [NREG-1:0] wr_sel, rd_sel;
  logic [PW-1:0]   pulse_q;
  logic [DW-1:0]   cfg_q, cap_q, rd_pulse, rd_mux;

  spr_decode #(.AW(AW), .NREG(NREG)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .wr_sel    (wr_sel),
    .rd_sel    (rd_sel)
  );

  for (genvar b = 0; b < PW; b++) begin : g_pulse
    spr_field #(.KIND(FK_PULSE), .W(1), .RST(1'b0)) u_bit (
      .clk      (clk),
      .rst      (rst),
      .sw_rd    (rd_sel[REG_PULSE]),
      .sw_wr    (wr_sel[REG_PULSE]),
      .sw_wdata (req_wdata[b]),
      .hw_we    (1'b0),
      .hw_wdata (1'b0),
      .q        (pulse_q[b])
    );
  end

  spr_field #(.KIND(FK_RW), .W(DW), .RST(CFG_RST)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .sw_rd    (rd_sel[REG_CFG]),
    .sw_wr    (wr_sel[REG_CFG]),
    .sw_wdata (req_wdata),
    .hw_we    (1'b0),
    .hw_wdata ('0),
    .q        (cfg_q)
  );

  spr_field #(.KIND(FK_CAPTURE), .W(DW), .RST('0)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .sw_rd    (rd_sel[REG_CAP]),
    .sw_wr    (wr_sel[REG_CAP]),
    .sw_wdata (req_wdata),
    .hw_we    (cap_we),
    .hw_wdata (cap_data),
    .q        (cap_q)
  );

  always_comb begin
    rd_pulse           = '0;
    rd_pulse[PW-1:0]   = pulse_q;
    rd_mux             = '0;
    if (rd_sel[REG_PULSE]) rd_mux = rd_pulse;
    else if (rd_sel[REG_CFG]) rd_mux = cfg_q;
    else if (rd_sel[REG_CAP]) rd_mux = cap_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_ready <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_ready <= req_valid;
      resp_rdata <= rd_mux;
    end
  end

  assign pulse_out = pulse_q;
  assign cfg_out   = cfg_q;
endmodule

// File: rtl/spr_regblock_chk.sv
module spr_regblock_chk #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8,
  parameter int unsigned PW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic          resp_ready,
  input logic [PW-1:0] pulse_out,
  input logic [DW-1:0] cfg_out,
  input logic [DW-1:0] cap_q
);
  logic          wr0, wr1, wr2, rd2;
  logic [PW-1:0] wr0_bits;
  assign wr0 = req_valid && req_write && (req_addr == AW'(0));
  assign wr1 = req_valid && req_write && (req_addr == AW'(1));
  assign wr2 = req_valid && req_write && (req_addr == AW'(2));
  assign rd2 = req_valid && !req_write && (req_addr == AW'(2));
  assign wr0_bits = wr0 ? req_wdata[PW-1:0] : '0;

  // R2 R3 R4: pulse outputs equal the previous cycle's address-0 write bits
  a_r2_pulse_follows_write: assert property (@(posedge clk) disable iff (rst)
    !rst |=> pulse_out == $past(wr0_bits));

  a_r10_ready_after_req: assert property (@(posedge clk) disable iff (rst)
    !rst |=> resp_ready == $past(req_valid));

  a_r6_cfg_holds: assert property (@(posedge clk) disable iff (rst)
    (!rst && !wr1) |=> $stable(cfg_out));

  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd2 |=> cap_q == '0);

  a_r9_write_sets: assert property (@(posedge clk) disable iff (rst)
    wr2 |=> (cap_q & $past(req_wdata)) == $past(req_wdata));
endmodule

bind spr_regblock spr_regblock_chk #(.AW(AW), .DW(DW), .PW(PW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .resp_ready (resp_ready),
  .pulse_out  (pulse_out),
  .cfg_out    (cfg_out),
  .cap_q      (cap_q)
);

// File: tb/sim_spr_regblock.sv
module sim_spr_regblock;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 8;
  localparam int unsigned PW = 4;
  localparam logic [DW-1:0] CFG_RST = 8'hA5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          cap_we = 1'b0;
  logic [DW-1:0] cap_data = '0;
  logic          resp_ready;
  logic [DW-1:0] resp_rdata;
  logic [PW-1:0] pulse_out;
  logic [DW-1:0] cfg_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_pulse, m_cfg, m_cap, m_ready, m_rdata;

  always #4 clk = ~clk;

  spr_regblock #(.AW(AW), .DW(DW), .PW(PW), .CFG_RST(CFG_RST)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_ready(resp_ready),
    .resp_rdata(resp_rdata), .pulse_out(pulse_out), .cfg_out(cfg_out),
    .cap_we(cap_we), .cap_data(cap_data)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int rdv;
    bit rd, wr;
    rd = req_valid && !req_write;
    wr = req_valid && req_write;
    if (rst) begin
      m_pulse = 0; m_cfg = CFG_RST; m_cap = 0; m_ready = 0; m_rdata = 0;
      return;
    end
    rdv = 0;
    if (rd) begin
      case (int'(req_addr))
        0: rdv = m_pulse;
        1: rdv = m_cfg;
        2: rdv = m_cap;
        default: rdv = 0;
      endcase
    end
    m_ready = req_valid;
    m_rdata = rdv;
    m_pulse = (wr && req_addr == 0) ? int'(req_wdata) % (1 << PW) : 0;
    if (wr && req_addr == 1) m_cfg = int'(req_wdata);
    if (rd && req_addr == 2) m_cap = 0;
    else if (wr && req_addr == 2) m_cap = m_cap | int'(req_wdata);
    else if (cap_we) m_cap = int'(cap_data);
  endtask

  task automatic compare_all();
    chk(int'(pulse_out) == m_pulse, "R2", "model pulse_out", int'(pulse_out), m_pulse);
    chk(int'(cfg_out) == m_cfg, "R6", "model cfg_out", int'(cfg_out), m_cfg);
    chk(int'(resp_ready) == m_ready, "R10", "model resp_ready", int'(resp_ready), m_ready);
    chk(int'(resp_rdata) == m_rdata, "R10", "model resp_rdata", int'(resp_rdata), m_rdata);
  endtask

  // one request cycle: drive, edge, model, sample at the falling edge
  task automatic cyc(input bit v, input bit w, input int a, input int d,
                     input bit we = 0, input int cd = 0);
    req_valid = v; req_write = w; req_addr = AW'(a); req_wdata = DW'(d);
    cap_we = we; cap_data = DW'(cd);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(); cyc(0, 0, 0, 0); endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1;
    repeat (3) cyc(0, 0, 0, 0);
    // R1 reset state
    chk(pulse_out == 0, "R1", "pulse_out", int'(pulse_out), 0);
    chk(cfg_out == CFG_RST, "R1", "cfg_out", int'(cfg_out), int'(CFG_RST));
    chk(resp_ready == 0, "R1", "resp_ready", int'(resp_ready), 0);
    rst = 0;
    idle();

    // R3 writing zero: no pulse
    cyc(1, 1, 0, 0);
    chk(pulse_out == 0, "R3", "pulse after zero write", int'(pulse_out), 0);
    idle();
    chk(pulse_out == 0, "R3", "pulse later", int'(pulse_out), 0);

    // R2 single pulse, one cycle
    cyc(1, 1, 0, 1);
    chk(pulse_out == 4'h1, "R2", "pulse high", int'(pulse_out), 1);
    idle();
    chk(pulse_out == 0, "R2", "pulse cleared", int'(pulse_out), 0);

    // R5 read after pulse returns 0, R10 ready
    cyc(1, 0, 0, 0);
    chk(resp_ready == 1, "R10", "ready after read", int'(resp_ready), 1);
    chk(resp_rdata == 0, "R5", "read after pulse", int'(resp_rdata), 0);

    // R4 back-to-back writes
    cyc(1, 1, 0, 5);
    chk(pulse_out == 4'h5, "R4", "b2b 1", int'(pulse_out), 5);
    cyc(1, 1, 0, 5);
    chk(pulse_out == 4'h5, "R4", "b2b 2", int'(pulse_out), 5);
    cyc(1, 1, 0, 8);
    chk(pulse_out == 4'h8, "R4", "b2b 3", int'(pulse_out), 8);
    idle();
    chk(pulse_out == 0, "R4", "b2b end", int'(pulse_out), 0);

    // R6 config register
    cyc(1, 1, 1, 8'h3C);
    idle(); idle();
    chk(cfg_out == 8'h3C, "R6", "cfg held", int'(cfg_out), 8'h3C);
    cyc(1, 0, 1, 0);
    chk(resp_rdata == 8'h3C, "R6", "cfg readback", int'(resp_rdata), 8'h3C);

    // R7 hardware capture, R8 read returns then clears
    cyc(0, 0, 0, 0, 1, 8'h12);
    idle();
    cyc(1, 0, 2, 0);
    chk(resp_rdata == 8'h12, "R7", "captured value", int'(resp_rdata), 8'h12);
    cyc(1, 0, 2, 0);
    chk(resp_rdata == 0, "R8", "cleared by read", int'(resp_rdata), 0);

    // R8 read-clear beats simultaneous hardware load
    cyc(1, 0, 2, 0, 1, 8'h77);
    chk(resp_rdata == 0, "R8", "read at collision", int'(resp_rdata), 0);
    cyc(1, 0, 2, 0);
    chk(resp_rdata == 0, "R8", "hw load lost", int'(resp_rdata), 0);

    // R9 write-to-set beats simultaneous hardware load
    cyc(0, 0, 0, 0, 1, 8'h01);
    cyc(1, 1, 2, 8'h30, 1, 8'h0F);
    chk(resp_rdata == 0, "R10", "write rdata zero", int'(resp_rdata), 0);
    cyc(1, 0, 2, 0);
    chk(resp_rdata == 8'h31, "R9", "or-set result", int'(resp_rdata), 8'h31);

    // R10 unmapped addresses
    cyc(1, 1, 7, 8'hFF);
    chk(cfg_out == 8'h3C, "R10", "unmapped write cfg", int'(cfg_out), 8'h3C);
    chk(pulse_out == 0, "R10", "unmapped write pulse", int'(pulse_out), 0);
    cyc(1, 0, 5, 0);
    chk(resp_rdata == 0, "R10", "unmapped read", int'(resp_rdata), 0);
    idle();
    chk(resp_ready == 0, "R10", "ready idle", int'(resp_ready), 0);

    // R11 reset mid-pulse
    cyc(1, 1, 0, 4'hF);
    chk(pulse_out == 4'hF, "R11", "pulse before reset", int'(pulse_out), 15);
    rst = 1;
    idle();
    chk(pulse_out == 0, "R11", "pulse after reset", int'(pulse_out), 0);
    chk(cfg_out == CFG_RST, "R11", "cfg after reset", int'(cfg_out), int'(CFG_RST));
    rst = 0;
    idle();
    cyc(1, 0, 2, 0);
    chk(resp_rdata == 0, "R11", "cap after reset", int'(resp_rdata), 0);
    idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule